// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets synchronous logic inside a chip use an external asynchronous static RAM of 8K bytes through a shared bidirectional data bus. A request on the internal side names an operation (read or write), a 13-bit word address and, for writes, a byte of data. The controller registers the request on a rising clock edge and performs the external access during the following clock period. It completes one access per period, so requests may arrive on every cycle.

Both halves of the clock period are used. Each access cycle starts with a clock-high half in which the address, write strobe and output strobe settle while the primary chip select stays inactive. In the clock-low half the primary chip select is active and, for a write, the controller drives the data bus. The next rising edge deasserts the primary select, and that rising select edge commits a write into the memory. For a read, the same edge samples the bus into an internal read register. A one-cycle completion pulse follows each access. Because the select depends on the clock phase, the clock period has to be at least twice the memory's access time. The secondary, active-high chip select is held permanently active.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted and after its release, with no request: the primary select, the write strobe and the output strobe are high, the completion pulse is low and the read register holds 0.
- R2: The secondary chip select output is high at all times.
- R3: A cycle that follows a clock edge at which no request was present keeps the primary select, the write strobe and the output strobe high, and the controller does not drive the data bus.
- R4: A write request (req_write = 1) sampled at a rising edge makes the next cycle a write cycle. In that cycle the write strobe is low and the output strobe is high for the whole period, and the address output equals the requested address. The primary select is high in the clock-high half and low in the clock-low half. The data bus carries the request's byte only in the clock-low half. The byte is stored at the address when the primary select rises at the end of the cycle.
- R5: A read request (req_write = 0) sampled at a rising edge makes the next cycle a read cycle. The output strobe is low, the write strobe is high, the address output equals the requested address, and the controller does not drive the bus. The primary select follows the same phase pattern as in R4.
- R6: At the end of a read cycle the byte on the bus is loaded into the read register. The register shows the value stored at the requested address from the rising edge that closes the read cycle.
- R7: Each accepted request, whether read or write, produces exactly one completion pulse. The pulse is high for the single cycle that follows its access cycle.
- R8: The write strobe and the output strobe are never low together.
- R9: The read register keeps its value through write cycles and idle cycles, and changes only at the end of a read cycle.
- R10: Requests on consecutive cycles are each served in their own consecutive access cycle, in request order, with mixed reads and writes. A read that directly follows a write to the same address returns the newly written byte.
- R11: All 13 address bits reach the memory unaltered, including the lowest address 0x0000 and the highest address 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both phases are used within an access |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present at this rising edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Registered byte from the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_ce1_n | output | 1 | Primary chip select, active low, low only in the clock-low half of an access |
| mem_ce2 | output | 1 | Secondary chip select, active high, held high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_addr | output | 13 | Address to the memory |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The properties assume that request inputs change only away from the rising clock edge and are stable when sampled. They also assume that the memory drives the bus only while its output strobe is low, so the controller's own release is the only bus condition under its control. The bench changes requests on falling edges, and its memory model drives only under a low output strobe. That model stores a byte only when the primary select rises during a write, using bus data taken late in the clock-low half. It also flags any address change at that commit instant. Idle cycles sit between and around bursts, so every ordering of idle, read and write cycles is exercised.

// File: rtl/sram_if_pkg.sv
`timescale 1ns/1ps
package sram_if_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  // Decode of a sampled request into the operation of the next cycle.
  function automatic sram_op_e op_from_req(input logic valid, input logic wr);
    if (!valid)  return OP_IDLE;
    else if (wr) return OP_WRITE;
    else         return OP_READ;
  endfunction

  // Active-low write strobe level for an operation.
  function automatic logic we_level(input sram_op_e op);
    return (op == OP_WRITE) ? 1'b0 : 1'b1;
  endfunction

  // Active-low output strobe level for an operation.
  function automatic logic oe_level(input sram_op_e op);
    return (op == OP_READ) ? 1'b0 : 1'b1;
  endfunction

  // Primary select is low only in the low half of a busy cycle.
  function automatic logic sel_level(input sram_op_e op, input logic clk_lvl);
    return !((op != OP_IDLE) && !clk_lvl);
  endfunction

endpackage

// File: rtl/sram_req_stage.sv
`timescale 1ns/1ps
module sram_req_stage
  import sram_if_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output sram_op_e          op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              we_n_q,
  output logic              oe_n_q
);

  sram_op_e op_next;

  always_comb op_next = op_from_req(req_valid, req_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q   <= op_next;
      we_n_q <= we_level(op_next);
      oe_n_q <= oe_level(op_next);
      if (req_valid) begin
        addr_q <= req_addr;
        if (req_write) wdata_q <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sram_bus_phase.sv
`timescale 1ns/1ps
module sram_bus_phase
  import sram_if_pkg::*;
(
  input  logic     clk,
  input  sram_op_e op_q,
  output logic     ce1_n,
  output logic     drv_en
);

  always_comb begin
    ce1_n  = sel_level(op_q, clk);
    drv_en = (op_q == OP_WRITE) && !clk;
  end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture
  import sram_if_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_op_e          op_q,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= (op_q != OP_IDLE);
      if (op_q == OP_READ) rd_data <= bus_in;
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
`timescale 1ns/1ps
module sram_port_ctrl
  import sram_if_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);

  sram_op_e          op_q;
  logic [DATA_W-1:0] wdata_q;
  logic              bus_drv_en;
  logic              cyc_busy;

  sram_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .op_q      (op_q),
    .addr_q    (mem_addr),
    .wdata_q   (wdata_q),
    .we_n_q    (mem_we_n),
    .oe_n_q    (mem_oe_n)
  );

  sram_bus_phase u_phase (
    .clk    (clk),
    .op_q   (op_q),
    .ce1_n  (mem_ce1_n),
    .drv_en (bus_drv_en)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_q    (op_q),
    .bus_in  (mem_dq),
    .rd_data (rd_data),
    .done    (done)
  );

  assign cyc_busy = (op_q != OP_IDLE);
  assign mem_ce2  = 1'b1;
  assign mem_dq   = bus_drv_en ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_port_ctrl_chk.sv
`timescale 1ns/1ps
module sram_port_ctrl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              done,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              bus_drv_en,
  input logic              cyc_busy
);

  a_r2_ce2_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce2);

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (mem_we_n && mem_oe_n && mem_ce1_n && !bus_drv_en && !cyc_busy));

  a_r4_write_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=>
      (!mem_we_n && mem_oe_n && !mem_ce1_n && mem_addr == $past(req_addr)));

  a_r5_read_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=>
      (!mem_oe_n && mem_we_n && !mem_ce1_n && !bus_drv_en && mem_addr == $past(req_addr)));

  a_r4_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drv_en |-> (!mem_we_n && mem_oe_n));

  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 done);

  a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ##1 !done);

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .done       (done),
  .mem_ce1_n  (mem_ce1_n),
  .mem_ce2    (mem_ce2),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_addr   (mem_addr),
  .bus_drv_en (bus_drv_en),
  .cyc_busy   (cyc_busy)
);

// File: tb/sram_port_ctrl_tb.sv
`timescale 1ns/1ps
module sram_port_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rd_data;
  logic        done;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n;
  logic [12:0] mem_addr;
  wire  [7:0]  mem_dq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_port_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .rd_data (rd_data), .done (done),
    .mem_ce1_n (mem_ce1_n), .mem_ce2 (mem_ce2), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_addr (mem_addr), .mem_dq (mem_dq)
  );

  // ---------------- memory model ----------------
  logic [7:0]  model_mem [int];
  logic [7:0]  exp_mem   [int];
  logic        model_drv;
  logic [7:0]  model_q;
  logic        pend = 1'b0;
  logic [12:0] pend_addr;
  logic [7:0]  pend_data;

  function automatic logic [7:0] model_rd(input logic [12:0] a);
    if (model_mem.exists(int'(a))) return model_mem[int'(a)];
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [12:0] a);
    if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
    return 8'h00;
  endfunction

  always @* begin
    model_drv = !mem_oe_n && mem_ce2;
    model_q   = model_rd(mem_addr);
  end

  assign mem_dq = model_drv ? model_q : 8'hzz;

  // Take bus data late in the clock-low half of a selected write.
  always begin
    @(negedge clk);
    #1.5;
    if (!mem_ce1_n && mem_ce2 && !mem_we_n) begin
      pend      = 1'b1;
      pend_addr = mem_addr;
      pend_data = mem_dq;
    end
  end

  // Commit on the rising primary select.
  always @(posedge mem_ce1_n) begin
    if (pend) begin
      chk(mem_addr == pend_addr, "R4", "address stable at commit", int'(mem_addr), int'(pend_addr));
      model_mem[int'(pend_addr)] = pend_data;
      pend = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(mem_ce1_n && mem_we_n && mem_oe_n, "R1", "strobes in reset",
        {mem_ce1_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!done && rd_data == 8'h00, "R1", "done/rd_data in reset", {done, rd_data}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(mem_ce1_n && mem_we_n && mem_oe_n && !done && rd_data == 8'h00, "R1",
        "state after reset", {mem_ce1_n, mem_we_n, mem_oe_n, done}, 4'b1110);
    chk(mem_ce2 == 1'b1, "R2", "secondary select", mem_ce2, 1);
  endtask

  task automatic t_idle();
    @(negedge clk); #1;
    chk(mem_ce1_n && mem_we_n && mem_oe_n, "R3", "idle low half",
        {mem_ce1_n, mem_we_n, mem_oe_n}, 3'b111);
    @(posedge clk); #1;
    chk(mem_ce1_n && mem_we_n && mem_oe_n && !done, "R3", "idle high half",
        {mem_ce1_n, mem_we_n, mem_oe_n, done}, 4'b1110);
  endtask

  task automatic t_access(input bit wr, input logic [12:0] a, input logic [7:0] d);
    logic [7:0] prev_rd;
    prev_rd = rd_data;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(mem_ce1_n == 1'b1, wr ? "R4" : "R5", "select high in clock-high half", mem_ce1_n, 1);
    chk(mem_we_n == !wr && mem_oe_n == wr, wr ? "R4" : "R5", "strobes",
        {mem_we_n, mem_oe_n}, {!wr, wr});
    chk(mem_addr == a, "R11", "address out", int'(mem_addr), int'(a));
    chk(mem_ce2 == 1'b1, "R2", "secondary select", mem_ce2, 1);
    @(negedge clk); #1;
    chk(mem_ce1_n == 1'b0, wr ? "R4" : "R5", "select low in clock-low half", mem_ce1_n, 0);
    chk(mem_we_n == !wr && mem_oe_n == wr, "R8", "strobes held in low half",
        {mem_we_n, mem_oe_n}, {!wr, wr});
    if (wr) chk(mem_dq == d, "R4", "bus carries write byte", int'(mem_dq), int'(d));
    @(posedge clk); #1;
    if (wr) exp_mem[int'(a)] = d;
    chk(done == 1'b1, "R7", "done after access", done, 1);
    if (wr) chk(rd_data == prev_rd, "R9", "rd_data kept over write", int'(rd_data), int'(prev_rd));
    else    chk(rd_data == exp_rd(a), "R6", "read byte", int'(rd_data), int'(exp_rd(a)));
    @(posedge clk); #1;
    chk(done == 1'b0, "R7", "single-cycle done", done, 0);
    chk(mem_we_n && mem_oe_n && mem_ce1_n, "R3", "idle after access",
        {mem_ce1_n, mem_we_n, mem_oe_n}, 3'b111);
  endtask

  task automatic t_burst();
    bit          b_wr   [5] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    logic [12:0] b_addr [5] = '{13'h0123, 13'h0123, 13'h1FFF, 13'h1FFF, 13'h0000};
    logic [7:0]  b_data [5] = '{8'h3C, 8'h00, 8'hE7, 8'h00, 8'h00};
    logic [7:0]  last_rd;
    last_rd = rd_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = b_wr[i]; req_addr = b_addr[i]; req_wdata = b_data[i];
      @(posedge clk); #1;
      if (i > 0) begin
        if (b_wr[i-1]) exp_mem[int'(b_addr[i-1])] = b_data[i-1];
        else last_rd = exp_rd(b_addr[i-1]);
        chk(done == 1'b1, "R10", "done each burst cycle", done, 1);
        chk(rd_data == last_rd, "R10", "burst rd_data", int'(rd_data), int'(last_rd));
      end
      chk(mem_we_n == !b_wr[i] && mem_oe_n == b_wr[i] && mem_addr == b_addr[i], "R10",
          "burst cycle strobes/address", {mem_we_n, mem_oe_n, mem_addr}, {!b_wr[i], b_wr[i], b_addr[i]});
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    last_rd = exp_rd(b_addr[4]);
    chk(done == 1'b1 && rd_data == last_rd, "R10", "burst tail read",
        int'(rd_data), int'(last_rd));
    @(posedge clk); #1;
    chk(done == 1'b0, "R7", "burst done ends", done, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_access(1'b0, 13'h0042, 8'h00);
    t_access(1'b1, 13'h0000, 8'h5A);
    t_access(1'b1, 13'h1FFF, 8'hA5);
    t_access(1'b1, 13'h0A5A, 8'hFF);
    t_access(1'b0, 13'h0000, 8'h00);
    t_access(1'b1, 13'h0777, 8'h01);
    t_idle();
    t_access(1'b0, 13'h1FFF, 8'h00);
    t_access(1'b0, 13'h0A5A, 8'h00);
    t_access(1'b1, 13'h0A5A, 8'h18);
    t_access(1'b0, 13'h0A5A, 8'h00);
    t_burst();
    t_idle();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule